// File: doc/BRIEF.md
# PCIe Interrupt Collector (INTx levels and MSI message queue)

This block merges the four legacy INTx level lines of a PCIe root port and the stream of inbound MSI memory writes into one host interrupt. INTx activity is latched into a miscellaneous status register. Software clears those bits by writing ones to them. A companion enable register selects which status bits may raise `host_irq`.

Inbound MSI writes are checked against a software-programmed address window. Only accepted writes are queued in a small hardware FIFO. Each FIFO entry holds the data word and both address words. Software drains the queue through a simple register port. The head entry leaves the queue only when all three of its words have been read. MSI vector n arrives as data n written to window base + 4*n. Software normally programs a 4096-byte window and then sets the MSI enable.

The register port is a single-cycle strobe interface. `reg_rdata` is combinational from the current state. The side effects of a read (the pop tracking) and of a write take hold at the rising edge where the strobe is sampled.

Top module: `pcie_irq_collector`

## Requirements
- R1: After synchronous reset, the following all read 0 and `host_irq` is low: misc status (0x40), misc enable (0x44), MSI status (0x18) and MSI enable (0x14).
- R2: A high level on `intx_lvl[k]` (k = 0..3) sets misc status bit 5+k at the next clock edge. So line A maps to bit 5 and line D maps to bit 8. The bit stays set after the line drops.
- R3: Writing 1 to an INTx bit of misc status (0x40) clears that bit, unless its line is still high in the same cycle. Writing 0 to a bit leaves it unchanged.
- R4: Misc status bit 3 reads 1 exactly while the MSI FIFO holds an entry. Writing to bit 3 has no effect on it.
- R5: Misc enable (0x44) stores only bits 8:5 and bit 3, and reads 0 elsewhere. `host_irq` is high exactly when misc status AND misc enable is non-zero.
- R6: An MSI write is queued only when MSI enable bit 0 (0x14) is set and the address lies in [base, base+size). The 64-bit base comes from 0x08 (high word) and 0x04 (low word). The size comes from 0x0C. Any other MSI write is dropped.
- R7: MSI status bit 0 (0x18) is 1 while the FIFO is non-empty. The head entry's data, low address word and high address word read at 0x20, 0x24 and 0x28.
- R8: The head entry is removed only after each of its three words has been read at least once, in any order. Repeated reads of the same word do not remove it.
- R9: An accepted MSI that arrives while the FIFO holds FIFO_DEPTH entries is dropped and sets sticky MSI status bit 1. Writing 1 to bit 1 of 0x18 clears it.
- R10: Entries are returned in arrival order.
- R11: Reading 0x20, 0x24 or 0x28 while the FIFO is empty returns 0 and has no effect on later entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_lvl | input | 4 | INTx level lines, A in bit 0 to D in bit 3 |
| msi_valid | input | 1 | Inbound MSI write strobe, one cycle per message |
| msi_addr | input | 64 | Address of the inbound MSI write |
| msi_data | input | 32 | Data of the inbound MSI write |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives pop tracking) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| host_irq | output | 1 | Combined host interrupt |

## Verification
The assertions assume the following about the inputs:
- `reg_wr` and `reg_rd` are never asserted in the same cycle.
- `intx_lvl`, `msi_*` and the register strobes change only away from the rising edge.
- FIFO_DEPTH is at least 2.

The stimulus keeps to these assumptions in the following way:
- Every input is driven at the falling edge.
- Register accesses are issued one at a time.
- MSI writes are always separate from register reads.

Given this, the pop-count and overflow properties only ever see one push source and one pop source per cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int REG_AW   = 8;
    localparam int N_INTX   = 4;
    localparam int INTX_LSB = 5;
    localparam int MSI_SUM  = 3;

    localparam logic [REG_AW-1:0] OFS_BASE_LO   = 8'h04;
    localparam logic [REG_AW-1:0] OFS_BASE_HI   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_WIN_SIZE  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_MSI_EN    = 8'h14;
    localparam logic [REG_AW-1:0] OFS_MSI_STAT  = 8'h18;
    localparam logic [REG_AW-1:0] OFS_MSI_DATA  = 8'h20;
    localparam logic [REG_AW-1:0] OFS_MSI_ALO   = 8'h24;
    localparam logic [REG_AW-1:0] OFS_MSI_AHI   = 8'h28;
    localparam logic [REG_AW-1:0] OFS_MISC_STAT = 8'h40;
    localparam logic [REG_AW-1:0] OFS_MISC_EN   = 8'h44;

    localparam logic [31:0] MISC_EN_MASK =
        (32'((1 << N_INTX) - 1) << INTX_LSB) | (32'd1 << MSI_SUM);

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
    } msi_entry_t;

    typedef enum logic [1:0] {
        W_DATA = 2'd0,
        W_ALO  = 2'd1,
        W_AHI  = 2'd2,
        W_NONE = 2'd3
    } msi_word_e;

    function automatic msi_word_e word_of(input logic [REG_AW-1:0] ofs);
        case (ofs)
            OFS_MSI_DATA: return W_DATA;
            OFS_MSI_ALO:  return W_ALO;
            OFS_MSI_AHI:  return W_AHI;
            default:      return W_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pirq_intx_status.sv
module pirq_intx_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_intx_latch_R2: assert property (@(posedge clk) disable iff (rst)
            lvl[i] |=> pend[i]);
        assert_intx_w1c_R3: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !lvl[i]) |=> !pend[i]);
        assert_intx_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && !clr[i]) |=> pend[i]);
    end
endmodule

// File: rtl/pirq_msi_window.sv
module pirq_msi_window (
    input  logic        en,
    input  logic [31:0] base_lo,
    input  logic [31:0] base_hi,
    input  logic [31:0] size,
    input  logic [63:0] addr,
    output logic        hit
);
    logic [63:0] base;
    logic [63:0] off;

    always_comb begin
        base = {base_hi, base_lo};
        off  = addr - base;
        hit  = en && (addr >= base) && (off < {32'd0, size});
    end
endmodule

// File: rtl/pirq_msi_fifo.sv
module pirq_msi_fifo
    import pirq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  msi_entry_t                 push_ent,
    input  logic                       pop,
    output msi_entry_t                 head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    msi_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_ent;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop) rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));
    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
        !(push && full));
    assert_pop_drains_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/pcie_irq_collector.sv
module pcie_irq_collector
    import pirq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_INTX-1:0]  intx_lvl,
    input  logic               msi_valid,
    input  logic [63:0]        msi_addr,
    input  logic [31:0]        msi_data,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               host_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [31:0] base_lo_q, base_hi_q, size_q, misc_en_q;
    logic        msi_en_q, ovf_q;
    logic [2:0]  seen_q, seen_nx;

    logic [N_INTX-1:0] intx_pend, intx_clr;
    logic              win_hit, push, pop, rd_word;
    logic              f_empty, f_full;
    logic [CNT_W-1:0]  f_count;
    msi_entry_t        f_head, in_ent;
    msi_word_e         word;
    logic [31:0]       misc_stat;

    function automatic logic wr_to(input logic [REG_AW-1:0] ofs,
                                   input logic w, input logic [REG_AW-1:0] a);
        return w && (a == ofs);
    endfunction

    assign intx_clr = wr_to(OFS_MISC_STAT, reg_wr, reg_addr)
                      ? reg_wdata[INTX_LSB +: N_INTX] : '0;

    pirq_intx_status #(.N(N_INTX)) u_intx (
        .clk  (clk),
        .rst  (rst),
        .lvl  (intx_lvl),
        .clr  (intx_clr),
        .pend (intx_pend)
    );

    pirq_msi_window u_win (
        .en      (msi_en_q),
        .base_lo (base_lo_q),
        .base_hi (base_hi_q),
        .size    (size_q),
        .addr    (msi_addr),
        .hit     (win_hit)
    );

    assign in_ent = '{data: msi_data, addr_lo: msi_addr[31:0], addr_hi: msi_addr[63:32]};
    assign push   = msi_valid && win_hit && !f_full;

    assign word    = word_of(reg_addr);
    assign rd_word = reg_rd && !f_empty && (word != W_NONE);
    assign seen_nx = seen_q | (3'b001 << word);
    assign pop     = rd_word && (seen_nx == 3'b111);

    pirq_msi_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (in_ent),
        .pop      (pop),
        .head     (f_head),
        .empty    (f_empty),
        .full     (f_full),
        .count    (f_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            size_q    <= '0;
            msi_en_q  <= 1'b0;
            misc_en_q <= '0;
            ovf_q     <= 1'b0;
            seen_q    <= '0;
        end else begin
            if (wr_to(OFS_BASE_LO, reg_wr, reg_addr))  base_lo_q <= reg_wdata;
            if (wr_to(OFS_BASE_HI, reg_wr, reg_addr))  base_hi_q <= reg_wdata;
            if (wr_to(OFS_WIN_SIZE, reg_wr, reg_addr)) size_q    <= reg_wdata;
            if (wr_to(OFS_MSI_EN, reg_wr, reg_addr))   msi_en_q  <= reg_wdata[0];
            if (wr_to(OFS_MISC_EN, reg_wr, reg_addr))  misc_en_q <= reg_wdata & MISC_EN_MASK;
            if (msi_valid && win_hit && f_full)
                ovf_q <= 1'b1;
            else if (wr_to(OFS_MSI_STAT, reg_wr, reg_addr) && reg_wdata[1])
                ovf_q <= 1'b0;
            if (pop)          seen_q <= '0;
            else if (rd_word) seen_q <= seen_nx;
        end
    end

    always_comb begin
        misc_stat = '0;
        misc_stat[INTX_LSB +: N_INTX] = intx_pend;
        misc_stat[MSI_SUM] = !f_empty;
    end

    assign host_irq = |(misc_stat & misc_en_q);

    always_comb begin
        case (reg_addr)
            OFS_BASE_LO:   reg_rdata = base_lo_q;
            OFS_BASE_HI:   reg_rdata = base_hi_q;
            OFS_WIN_SIZE:  reg_rdata = size_q;
            OFS_MSI_EN:    reg_rdata = {31'd0, msi_en_q};
            OFS_MSI_STAT:  reg_rdata = {30'd0, ovf_q, !f_empty};
            OFS_MSI_DATA:  reg_rdata = f_empty ? '0 : f_head.data;
            OFS_MSI_ALO:   reg_rdata = f_empty ? '0 : f_head.addr_lo;
            OFS_MSI_AHI:   reg_rdata = f_empty ? '0 : f_head.addr_hi;
            OFS_MISC_STAT: reg_rdata = misc_stat;
            OFS_MISC_EN:   reg_rdata = misc_en_q;
            default:       reg_rdata = '0;
        endcase
    end

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && win_hit && f_full) |=> ovf_q);
    assert_drop_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && !msi_en_q) |=> (f_count <= $past(f_count)));
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (misc_en_q == '0) |-> !host_irq);
    assert_single_read_no_pop_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_word && seen_q == '0) |=> (f_count >= $past(f_count)));
endmodule

// File: tb/pcie_irq_collector_bench.sv
module pcie_irq_collector_bench;
    import pirq_pkg::*;

    localparam int DEPTH = 4;
    localparam logic [31:0] B_LO = 32'h2000_0000;
    localparam logic [31:0] B_HI = 32'h0000_0001;
    localparam logic [63:0] BASE = {B_HI, B_LO};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  intx_lvl = '0;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pcie_irq_collector #(.FIFO_DEPTH(DEPTH)) u_pcie_irq_collector (
        .clk(clk), .rst(rst), .intx_lvl(intx_lvl), .msi_valid(msi_valid),
        .msi_addr(msi_addr), .msi_data(msi_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic msi(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFS_MISC_STAT, v); chk("R1 misc status", v, 32'h0);
        rd(OFS_MISC_EN, v);   chk("R1 misc enable", v, 32'h0);
        rd(OFS_MSI_STAT, v);  chk("R1 msi status", v, 32'h0);
        rd(OFS_MSI_EN, v);    chk("R1 msi enable", v, 32'h0);
        chk("R1 host_irq", 32'(host_irq), 32'h0);

        // R5 enable mask
        wr(OFS_MISC_EN, 32'hFFFF_FFFF);
        rd(OFS_MISC_EN, v); chk("R5 enable mask", v, 32'h0000_01E8);

        // R2/R3 INTx sweep
        for (int k = 0; k < 4; k++) begin
            intx_lvl = 4'(1 << k);
            rd(OFS_MISC_STAT, v); chk("R2 intx latch", v, 32'(1 << (5 + k)));
            chk("R5 irq on intx", 32'(host_irq), 32'h1);
            wr(OFS_MISC_STAT, 32'(1 << (5 + k)));
            rd(OFS_MISC_STAT, v); chk("R3 clear while held", v, 32'(1 << (5 + k)));
            intx_lvl = '0;
            rd(OFS_MISC_STAT, v); chk("R2 sticky", v, 32'(1 << (5 + k)));
            wr(OFS_MISC_STAT, 32'h0);
            rd(OFS_MISC_STAT, v); chk("R3 write zero", v, 32'(1 << (5 + k)));
            wr(OFS_MISC_STAT, 32'(1 << (5 + k)));
            rd(OFS_MISC_STAT, v); chk("R3 w1c", v, 32'h0);
            chk("R5 irq low", 32'(host_irq), 32'h0);
        end

        // R5 gating by enable
        wr(OFS_MISC_EN, 32'h0000_00C8);
        intx_lvl = 4'b0001;
        @(negedge clk); intx_lvl = '0;
        rd(OFS_MISC_STAT, v); chk("R2 line A", v, 32'h20);
        chk("R5 gated irq", 32'(host_irq), 32'h0);
        wr(OFS_MISC_STAT, 32'h20);
        wr(OFS_MISC_EN, 32'h0000_01E8);

        // program the window
        wr(OFS_BASE_LO, B_LO); wr(OFS_BASE_HI, B_HI); wr(OFS_WIN_SIZE, 32'd4096);
        rd(OFS_BASE_LO, v); chk("R6 base low", v, B_LO);
        rd(OFS_WIN_SIZE, v); chk("R6 size", v, 32'd4096);

        // R6 disabled drop
        msi(BASE, 32'd0);
        rd(OFS_MSI_STAT, v); chk("R6 disabled drop", v, 32'h0);
        wr(OFS_MSI_EN, 32'h1);

        // R11 empty reads
        rd(OFS_MSI_DATA, v); chk("R11 empty data", v, 32'h0);
        rd(OFS_MSI_AHI, v);  chk("R11 empty ahi", v, 32'h0);

        // R7/R8/R10 full vector sweep in batches
        for (int b = 0; b < 16 / DEPTH; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                int n = b * DEPTH + i;
                msi(BASE + 64'(4 * n), 32'(n));
            end
            rd(OFS_MSI_STAT, v); chk("R7 nonempty", v, 32'h1);
            rd(OFS_MISC_STAT, v); chk("R4 summary bit", v, 32'h8);
            chk("R5 irq on msi", 32'(host_irq), 32'h1);
            for (int i = 0; i < DEPTH; i++) begin
                int n = b * DEPTH + i;
                logic [31:0] exp_lo;
                exp_lo = B_LO + 32'(4 * n);
                if (i % 2 == 0) begin
                    rd(OFS_MSI_DATA, v); chk("R10 order data", v, 32'(n));
                    rd(OFS_MSI_DATA, v); chk("R8 repeat data", v, 32'(n));
                    rd(OFS_MSI_ALO, v);  chk("R7 addr low", v, exp_lo);
                    rd(OFS_MSI_DATA, v); chk("R8 no pop yet", v, 32'(n));
                    rd(OFS_MSI_AHI, v);  chk("R7 addr high", v, B_HI);
                end else begin
                    rd(OFS_MSI_AHI, v);  chk("R7 addr high", v, B_HI);
                    rd(OFS_MSI_DATA, v); chk("R10 order data", v, 32'(n));
                    rd(OFS_MSI_ALO, v);  chk("R7 addr low", v, exp_lo);
                end
            end
            rd(OFS_MSI_STAT, v); chk("R7 drained", v, 32'h0);
        end
        chk("R5 irq after drain", 32'(host_irq), 32'h0);

        // R9 overflow
        for (int i = 0; i <= DEPTH; i++) msi(BASE + 64'(4 * i), 32'(i));
        rd(OFS_MSI_STAT, v); chk("R9 overflow set", v, 32'h3);
        wr(OFS_MISC_STAT, 32'h8);
        rd(OFS_MISC_STAT, v); chk("R4 bit3 not clearable", v, 32'h8);
        for (int i = 0; i < DEPTH; i++) begin
            rd(OFS_MSI_DATA, v); chk("R9 kept entry", v, 32'(i));
            rd(OFS_MSI_ALO, v); rd(OFS_MSI_AHI, v);
        end
        rd(OFS_MSI_STAT, v); chk("R9 extra dropped", v, 32'h2);
        wr(OFS_MSI_STAT, 32'h2);
        rd(OFS_MSI_STAT, v); chk("R9 sticky cleared", v, 32'h0);

        // R6 window edges
        msi(BASE - 64'd4, 32'hAA);
        msi(BASE + 64'd4096, 32'hBB);
        rd(OFS_MSI_STAT, v); chk("R6 outside dropped", v, 32'h0);
        msi(BASE + 64'd4092, 32'hCC);
        rd(OFS_MSI_DATA, v); chk("R6 last word accepted", v, 32'hCC);
        rd(OFS_MSI_ALO, v);  chk("R6 last addr", v, B_LO + 32'd4092);
        rd(OFS_MSI_AHI, v);
        rd(OFS_MSI_STAT, v); chk("R8 popped", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule